// File: doc/BRIEF.md
# Quadrature and Pulse-Direction Decoder

This block converts the A, B and index inputs of one encoder channel into single-cycle count-up, count-down and index pulses for a counter that lives outside the block. A two-bit mode input selects pulse/direction counting or one of three quadrature resolutions (x1, x2, x4). All three inputs are first brought into the clock domain by a synchronizer chain, then cleaned by a digital glitch filter whose sampling rate is set by an 8-bit prescaler.

A sticky error flag reports an A/B edge pair that reaches the filter output in the same cycle, which means the encoder moved faster than the filter can resolve. The index input has selectable active level, and an optional gated mode in which an index is only accepted while A and B are both high. The gated mode takes effect only in the quadrature modes.

Top module: `quad_decoder`

## Requirements
- R1: After reset, cnt_up, cnt_dn, idx_pulse and err_flag are all low, and no pulse appears while the inputs stay low.
- R2: With mode = 2'b00 (pulse/direction), each rising edge of A gives one pulse; B high makes it cnt_up, B low makes it cnt_dn; edges of B alone and falling edges of A give nothing.
- R3: With mode = 2'b01 (x1), a rising edge of A while B is low gives cnt_up and a falling edge of A while B is low gives cnt_dn; B edges and A edges while B is high give nothing, so one full cycle gives one pulse.
- R4: With mode = 2'b10 (x2), both edges of A count: A rising with B low or A falling with B high is up, the other two cases are down; two pulses per full cycle.
- R5: With mode = 2'b11 (x4), both edges of A and of B count; the sequence AB = 00,10,11,01 (A leading B) counts up, its reverse counts down; four pulses per full cycle.
- R6: The filter samples once per filter tick, one tick every psc_div+1 clocks (psc_div = 0: every clock); a filtered input takes a new level only after that level is seen at two consecutive ticks, so a shorter glitch is dropped.
- R7: If filtered A and filtered B change in the same cycle, no count pulse is produced for it and err_flag goes high and stays high until reset.
- R8: idx_pol = 1 makes a high index active, idx_pol = 0 a low one; one idx_pulse is given each time the filtered index becomes active.
- R9: With idx_sync = 1 in a quadrature mode, an index is accepted only if filtered A and B are both high; in pulse/direction mode idx_sync has no effect.
- R10: Every output pulse is one clock wide and cnt_up and cnt_dn are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_a | input | 1 | Encoder phase A (or pulse), asynchronous |
| enc_b | input | 1 | Encoder phase B (or direction), asynchronous |
| enc_idx | input | 1 | Encoder index, asynchronous |
| mode | input | 2 | 00 pulse/direction, 01 x1, 10 x2, 11 x4 |
| idx_pol | input | 1 | Index active level, 1 = high |
| idx_sync | input | 1 | Gate index with A and B both high |
| psc_div | input | PSC_W | Filter tick divider, tick every psc_div+1 clocks |
| cnt_up | output | 1 | One-cycle count-up pulse |
| cnt_dn | output | 1 | One-cycle count-down pulse |
| idx_pulse | output | 1 | One-cycle index pulse |
| err_flag | output | 1 | Sticky too-fast-edge error |

## Verification
The properties assume that mode, idx_pol and idx_sync stay constant while edges travel through the pipeline, and that psc_div only changes at quiet times; the spacing property is only claimed while psc_div holds. The stimulus changes configuration only after several idle cycles, holds every A/B state far longer than the filter latency, and moves A and B together only in the one test that targets the error flag.

// File: rtl/qd_pkg.sv
package qd_pkg;
  typedef enum logic [1:0] {
    QD_PULSE_DIR = 2'b00,
    QD_X1        = 2'b01,
    QD_X2        = 2'b10,
    QD_X4        = 2'b11
  } qd_mode_e;

  localparam int QD_NUM_IN = 3;  // A, B, index
  localparam int QD_BIT_A  = 0;
  localparam int QD_BIT_B  = 1;
  localparam int QD_BIT_I  = 2;
endpackage

// File: rtl/qd_sync.sv
module qd_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      logic [W-1:0] stage_d;
      if (g == 0) begin : g_first
        assign stage_d = d;
      end else begin : g_next
        assign stage_d = stage_q[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= stage_d;
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/qd_tick.sv
module qd_tick #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] div,
  output logic          tick
);
  logic [PW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = (cnt_q >= div);
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/qd_filter.sv
module qd_filter #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_bit
      logic filt_q, filt_d, pend_q, pend_d;

      always_comb begin
        filt_d = filt_q;
        pend_d = pend_q;
        if (tick) begin
          if (d[g] == filt_q) begin
            pend_d = 1'b0;
          end else if (pend_q) begin
            filt_d = d[g];
            pend_d = 1'b0;
          end else begin
            pend_d = 1'b1;
          end
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          filt_q <= 1'b0;
          pend_q <= 1'b0;
        end else begin
          filt_q <= filt_d;
          pend_q <= pend_d;
        end
      end

      assign q[g] = filt_q;
    end
  endgenerate
endmodule

// File: rtl/qd_decode.sv
module qd_decode
  import qd_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  qd_mode_e mode,
  input  logic     a,
  input  logic     b,
  input  logic     idx,
  input  logic     idx_pol,
  input  logic     idx_sync,
  output logic     up,
  output logic     dn,
  output logic     idx_p,
  output logic     err
);
  logic pa_q, pb_q, act_q;
  logic up_q, dn_q, idx_q, err_q;
  logic up_d, dn_d, idx_d, err_d, act_d;
  logic a_r, a_f, b_r, b_f, both_chg, sync_eff;

  always_comb begin
    a_r      = a & ~pa_q;
    a_f      = ~a & pa_q;
    b_r      = b & ~pb_q;
    b_f      = ~b & pb_q;
    both_chg = (a ^ pa_q) & (b ^ pb_q);
    up_d     = 1'b0;
    dn_d     = 1'b0;
    unique case (mode)
      QD_PULSE_DIR: begin
        up_d = a_r & b;
        dn_d = a_r & ~b;
      end
      QD_X1: begin
        up_d = a_r & ~b;
        dn_d = a_f & ~b;
      end
      QD_X2: begin
        up_d = (a_r & ~b) | (a_f & b);
        dn_d = (a_r & b)  | (a_f & ~b);
      end
      QD_X4: begin
        up_d = (a_r & ~b) | (a_f & b) | (b_r & a) | (b_f & ~a);
        dn_d = (a_r & b)  | (a_f & ~b) | (b_r & ~a) | (b_f & a);
      end
      default: begin
        up_d = 1'b0;
        dn_d = 1'b0;
      end
    endcase
    if (both_chg) begin
      up_d = 1'b0;
      dn_d = 1'b0;
    end
    err_d    = err_q | both_chg;
    act_d    = idx_pol ? idx : ~idx;
    sync_eff = idx_sync && (mode != QD_PULSE_DIR);
    idx_d    = act_d & ~act_q & (~sync_eff | (a & b));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa_q  <= 1'b0;
      pb_q  <= 1'b0;
      act_q <= 1'b0;
      up_q  <= 1'b0;
      dn_q  <= 1'b0;
      idx_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      pa_q  <= a;
      pb_q  <= b;
      act_q <= act_d;
      up_q  <= up_d;
      dn_q  <= dn_d;
      idx_q <= idx_d;
      err_q <= err_d;
    end
  end

  assign up    = up_q;
  assign dn    = dn_q;
  assign idx_p = idx_q;
  assign err   = err_q;
endmodule

// File: rtl/quad_decoder.sv
module quad_decoder
  import qd_pkg::*;
#(
  parameter int PSC_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enc_a,
  input  logic             enc_b,
  input  logic             enc_idx,
  input  logic [1:0]       mode,
  input  logic             idx_pol,
  input  logic             idx_sync,
  input  logic [PSC_W-1:0] psc_div,
  output logic             cnt_up,
  output logic             cnt_dn,
  output logic             idx_pulse,
  output logic             err_flag
);
  logic [QD_NUM_IN-1:0] raw, synced, filt;
  logic                 flt_tick;

  assign raw = {enc_idx, enc_b, enc_a};

  qd_sync #(.W(QD_NUM_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(synced)
  );

  qd_tick #(.PW(PSC_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .div(psc_div), .tick(flt_tick)
  );

  qd_filter #(.W(QD_NUM_IN)) u_filt (
    .clk(clk), .rst_n(rst_n), .tick(flt_tick), .d(synced), .q(filt)
  );

  qd_decode u_dec (
    .clk(clk), .rst_n(rst_n), .mode(qd_mode_e'(mode)),
    .a(filt[QD_BIT_A]), .b(filt[QD_BIT_B]), .idx(filt[QD_BIT_I]),
    .idx_pol(idx_pol), .idx_sync(idx_sync),
    .up(cnt_up), .dn(cnt_dn), .idx_p(idx_pulse), .err(err_flag)
  );
endmodule

// File: rtl/qd_chk.sv
module qd_chk #(
  parameter int PSC_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode,
  input logic             idx_sync,
  input logic [PSC_W-1:0] psc_div,
  input logic             tick,
  input logic             f_a,
  input logic             f_b,
  input logic             cnt_up,
  input logic             cnt_dn,
  input logic             idx_pulse,
  input logic             err_flag
);
  AST_UP_DN_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(cnt_up && cnt_dn));  // R10

  AST_IDX_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    idx_pulse |=> !idx_pulse);  // R8

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);  // R7

  AST_DOUBLE_EDGE_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    ((f_a != $past(f_a)) && (f_b != $past(f_b))) |=> (!cnt_up && !cnt_dn && err_flag));  // R7

  AST_X1_A_EDGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(mode) == 2'b01) && (cnt_up || cnt_dn)) |-> ($past(f_a) != $past(f_a, 2)));  // R3

  AST_SYNC_IDX_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_pulse && $past(idx_sync) && ($past(mode) != 2'b00)) |-> ($past(f_a) && $past(f_b)));  // R9

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (psc_div != '0) && $stable(psc_div)) |=> !tick);  // R6
endmodule

bind quad_decoder qd_chk #(.PSC_W(PSC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .idx_sync(idx_sync),
  .psc_div(psc_div), .tick(flt_tick),
  .f_a(filt[qd_pkg::QD_BIT_A]), .f_b(filt[qd_pkg::QD_BIT_B]),
  .cnt_up(cnt_up), .cnt_dn(cnt_dn), .idx_pulse(idx_pulse), .err_flag(err_flag)
);

// File: tb/sim_quad_decoder.sv
`timescale 1ns/1ps
module sim_quad_decoder;
  localparam int HOLD = 8;

  typedef struct packed {
    logic [1:0] m;   // mode
    logic [1:0] k;   // 0 fwd quad, 1 back quad, 2 A pulses B=1, 3 A pulses B=0
    logic [3:0] n;
    logic [7:0] eu;
    logic [7:0] ed;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VT [NV] = '{
    '{2'd0, 2'd2, 4'd3, 8'd3, 8'd0},  // R2
    '{2'd0, 2'd3, 4'd2, 8'd0, 8'd2},  // R2
    '{2'd0, 2'd0, 4'd2, 8'd0, 8'd2},  // R2 B low at A rise
    '{2'd1, 2'd0, 4'd3, 8'd3, 8'd0},  // R3
    '{2'd1, 2'd1, 4'd2, 8'd0, 8'd2},  // R3
    '{2'd1, 2'd2, 4'd2, 8'd0, 8'd0},  // R3 B high: nothing
    '{2'd2, 2'd0, 4'd2, 8'd4, 8'd0},  // R4
    '{2'd2, 2'd1, 4'd3, 8'd0, 8'd6},  // R4
    '{2'd3, 2'd0, 4'd2, 8'd8, 8'd0},  // R5
    '{2'd3, 2'd1, 4'd1, 8'd0, 8'd4}   // R5
  };

  logic clk = 1'b0;
  logic rst_n;
  logic enc_a, enc_b, enc_idx, idx_pol, idx_sync;
  logic [1:0] mode;
  logic [7:0] psc_div;
  logic cnt_up, cnt_dn, idx_pulse, err_flag;

  int n_chk = 0, n_bad = 0;
  int ups = 0, dns = 0, idxs = 0;
  bit done = 0;

  always #2 clk = ~clk;

  quad_decoder u0 (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b), .enc_idx(enc_idx),
    .mode(mode), .idx_pol(idx_pol), .idx_sync(idx_sync), .psc_div(psc_div),
    .cnt_up(cnt_up), .cnt_dn(cnt_dn), .idx_pulse(idx_pulse), .err_flag(err_flag)
  );

  always @(negedge clk) begin
    if (cnt_up)    ups++;
    if (cnt_dn)    dns++;
    if (idx_pulse) idxs++;
    if (cnt_up && cnt_dn) begin
      n_chk++; n_bad++;
      $display("FAIL R10: up and down together, actual 1/1 expected not both");
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int c);
    repeat (c) @(negedge clk);
  endtask

  task automatic step(input logic a, input logic b, input int h);
    enc_a = a; enc_b = b;
    idle(h);
  endtask

  task automatic clr();
    ups = 0; dns = 0; idxs = 0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(2);
  endtask

  task automatic pulse_idx(input logic active, input int h);
    enc_idx = active; idle(h);
    enc_idx = ~active; idle(h);
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    enc_a = 0; enc_b = 0; enc_idx = 0; idx_pol = 1; idx_sync = 0;
    mode = 2'b00; psc_div = 8'd0;
    do_reset();
    clr();
    idle(20);
    // R1 reset state
    chk("R1 cnt_up", int'(cnt_up), 0);
    chk("R1 err_flag", int'(err_flag), 0);
    chk("R1 no pulses", ups + dns + idxs, 0);

    // table walk: R2..R5
    for (int v = 0; v < NV; v++) begin
      mode = VT[v].m;
      idle(HOLD);
      clr();
      for (int i = 0; i < int'(VT[v].n); i++) begin
        case (VT[v].k)
          2'd0: begin step(1,0,HOLD); step(1,1,HOLD); step(0,1,HOLD); step(0,0,HOLD); end
          2'd1: begin step(0,1,HOLD); step(1,1,HOLD); step(1,0,HOLD); step(0,0,HOLD); end
          2'd2: begin step(0,1,HOLD); step(1,1,HOLD); step(0,1,HOLD); end
          default: begin step(1,0,HOLD); step(0,0,HOLD); end
        endcase
      end
      idle(HOLD);
      if (VT[v].k == 2'd2) begin
        step(0,0,HOLD);
        idle(HOLD);
      end
      chk($sformatf("R2-5 vec%0d mode%0d up", v, VT[v].m), ups, int'(VT[v].eu));
      chk($sformatf("R2-5 vec%0d mode%0d dn", v, VT[v].m), dns, int'(VT[v].ed));
    end
    chk("R7 no error in clean runs", int'(err_flag), 0);

    // R6 glitch shorter than two ticks is dropped at psc_div = 7
    mode = 2'b11; psc_div = 8'd7; idle(HOLD); clr();
    step(1,0,3); step(0,0,60);
    chk("R6 glitch dropped", ups + dns, 0);
    // R6 long level accepted at psc_div = 7
    clr();
    step(1,0,60); step(0,0,60);
    chk("R6 slow up", ups, 1);
    chk("R6 slow dn", dns, 1);
    // R6 same short glitch passes at psc_div = 0
    psc_div = 8'd0; idle(HOLD); clr();
    step(1,0,3); step(0,0,HOLD);
    chk("R6 short pulse at div 0", ups + dns, 2);

    // R8 index polarity
    clr(); idx_pol = 1; enc_idx = 0; idle(HOLD); clr();
    pulse_idx(1'b1, HOLD);
    chk("R8 active high", idxs, 1);
    idx_pol = 0; enc_idx = 1; idle(HOLD); clr();
    pulse_idx(1'b0, HOLD);
    chk("R8 active low", idxs, 1);
    clr();
    enc_idx = 1; idle(HOLD); enc_idx = 0; idle(HOLD); enc_idx = 1; idle(HOLD);
    chk("R8 one pulse per activation", idxs, 1);

    // R9 synchronous index gating
    idx_pol = 1; enc_idx = 0; idx_sync = 1; mode = 2'b11; idle(HOLD); clr();
    pulse_idx(1'b1, HOLD);
    chk("R9 gated with AB=00", idxs, 0);
    step(1,0,HOLD); step(1,1,HOLD); clr();
    pulse_idx(1'b1, HOLD);
    chk("R9 accepted with AB=11", idxs, 1);
    step(0,1,HOLD); step(0,0,HOLD);
    mode = 2'b00; idle(HOLD); clr();
    pulse_idx(1'b1, HOLD);
    chk("R9 sync ignored in pulse/dir", idxs, 1);
    idx_sync = 0;

    // R7 simultaneous A/B change
    mode = 2'b11; idle(HOLD); clr();
    step(1,1,HOLD);
    chk("R7 no count on double edge", ups + dns, 0);
    chk("R7 error set", int'(err_flag), 1);
    step(0,1,HOLD); step(0,0,HOLD);
    chk("R7 error sticky", int'(err_flag), 1);
    do_reset();
    chk("R1 error cleared by reset", int'(err_flag), 0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule